// File: doc/BRIEF.md
# Counting Phase/Frequency Detector with Programmable Update Strobe

This block measures how far a feedback clock has drifted from a reference clock, working entirely in one system clock domain. Each clock arrives as a single-cycle enable. Each enable drives its own programmable divider, which divides by its setting plus two. Every divider wrap is a divided event. A signed accumulator adds one for each reference event and subtracts one for each feedback event.

A free-running rate counter issues a periodic update strobe. In the strobe cycle, the accumulated difference is handed to the error output, which feeds a loop filter. In the same cycle the accumulator restarts from zero. The error word saturates at its signed range. A sticky flag records that saturation took place.

A loop filter samples `err_o` once after each `strobe_o`. It uses `ovf_o` to tell that a measurement was clipped.

Top module: `phase_count_det`

## Requirements
- R1: While `rst_ni` is low, `err_o` is zero and `ovf_o` is low. Releasing reset restarts both dividers, the accumulator and the rate counter from zero.
- R2: With `ref_ce_i` held high, the reference path produces one divided event every `ref_div_i`+2 cycles, for any 16-bit setting.
- R3: With `fb_ce_i` held high, the feedback path produces one divided event every `fb_div_i`+2 cycles, for any 16-bit setting.
- R4: A divider advances only in cycles where its enable is high. In a cycle with a low enable, the divider neither counts nor produces an event.
- R5: The error presented after a strobe is computed from the strobe cycle's own events and all events since the previous strobe. Its value is the number of reference events minus the number of feedback events, as an `ERR_W`-bit two's-complement value.
- R6: `strobe_o` is high in a cycle exactly when the rate counter is greater than or equal to `rate_i`. The counter starts at zero after reset, returns to zero after a strobe and increments otherwise. A fixed setting N therefore gives one single-cycle pulse every N+1 cycles, and a setting of 0 keeps the strobe high every cycle.
- R7: `err_o` changes only at the clock edge that ends a strobe cycle and holds its value between strobes. The accumulator restarts from zero after each strobe.
- R8: Accumulation saturates at +(2^(ERR_W-1)-1) and -(2^(ERR_W-1)). A step that would pass either limit is clipped, and `ovf_o` goes high at the next edge.
- R9: Once `ovf_o` is high, it stays high through later strobes and in-range traffic until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_ce_i | input | 1 | Reference clock enable, one pulse per reference edge |
| fb_ce_i | input | 1 | Feedback clock enable, one pulse per feedback edge |
| ref_div_i | input | 16 | Reference divider setting, divides by value+2 |
| fb_div_i | input | 16 | Feedback divider setting, divides by value+2 |
| rate_i | input | 16 | Update period setting, strobe every value+1 cycles |
| err_o | output | ERR_W (21) | Signed error, reference minus feedback events |
| strobe_o | output | 1 | Update strobe |
| ovf_o | output | 1 | Sticky error saturation flag |

## Verification
`strobe_o` is a combinational function of the registered rate count and `rate_i`, so it is due in the same cycle as the state that causes it. `err_o` and `ovf_o` change one edge after the strobe or saturating step that causes them. Divider events feed the accumulator in the cycle they occur, so an event in a strobe cycle lands in that strobe's error. A behavioural model advances at each rising edge from the inputs the bench drove at the previous falling edge. The bench compares all three outputs against this model at every falling edge, before it drives the next inputs, so each expected value is taken exactly where it falls due.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam int unsigned NUM_PATHS = 2;
  localparam int unsigned PATH_REF  = 0;
  localparam int unsigned PATH_FB   = 1;
endpackage

// File: rtl/pcd_edge_div.sv
module pcd_edge_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // terminal count is div+1, so period is div+2 enabled cycles
  assign lim    = {1'b0, div_i} + CNT_W'(1);
  assign tick_o = ce_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (ce_i) cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
  end

  a_r4_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(cnt_q));
  a_r4_no_tick_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |-> !tick_o);
  a_r2_wrap_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0);
  a_r2_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !tick_o) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/pcd_rate_gen.sv
module pcd_rate_gen #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              strobe_o
);
  logic [RATE_W-1:0] cnt_q;

  // >= lets a shrinking setting recover at once instead of wrapping
  assign strobe_o = cnt_q >= rate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= strobe_o ? '0 : cnt_q + RATE_W'(1);
  end

  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> cnt_q == '0);
  a_r6_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |=> cnt_q == $past(cnt_q) + RATE_W'(1));
endmodule

// File: rtl/pcd_diff_acc.sv
module pcd_diff_acc
  import pcd_pkg::*;
#(
  parameter int unsigned ERR_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             strobe_i,
  output logic [ERR_W-1:0] err_o,
  output logic             ovf_o
);
  localparam int unsigned WIDE_W = ERR_W + 1;
  localparam logic signed [WIDE_W-1:0] SAT_HI = {2'b00, {(ERR_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] SAT_LO = {2'b11, {(ERR_W-1){1'b0}}};

  step_e                     step;
  logic        [ERR_W-1:0]   acc_q;
  logic        [ERR_W-1:0]   err_q;
  logic                      ovf_q;
  logic signed [WIDE_W-1:0]  wide;
  logic signed [WIDE_W-1:0]  sum;
  logic                      hit_hi;
  logic                      hit_lo;
  logic        [ERR_W-1:0]   sat_val;

  always_comb begin
    if (up_i && !dn_i)      step = STEP_UP;
    else if (dn_i && !up_i) step = STEP_DOWN;
    else                    step = STEP_NONE;
  end

  assign wide = $signed({acc_q[ERR_W-1], acc_q});

  always_comb begin
    unique case (step)
      STEP_UP:   sum = wide + WIDE_W'(1);
      STEP_DOWN: sum = wide - WIDE_W'(1);
      default:   sum = wide;
    endcase
  end

  assign hit_hi = sum > SAT_HI;
  assign hit_lo = sum < SAT_LO;

  always_comb begin
    if (hit_hi)      sat_val = SAT_HI[ERR_W-1:0];
    else if (hit_lo) sat_val = SAT_LO[ERR_W-1:0];
    else             sat_val = sum[ERR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      err_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= strobe_i ? '0 : sat_val;
      if (strobe_i) err_q <= sat_val;
      if (hit_hi || hit_lo) ovf_q <= 1'b1;
    end
  end

  assign err_o = err_q;
  assign ovf_o = ovf_q;

  a_r7_clear_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> acc_q == '0);
  a_r7_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(err_q));
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r8_flag_on_clip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_hi || hit_lo) |=> ovf_q);
  a_r5_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(strobe_i) && !strobe_i |->
      ($signed(acc_q) - $signed($past(acc_q)) <= 1) &&
      ($signed($past(acc_q)) - $signed(acc_q) <= 1));
endmodule

// File: rtl/phase_count_det.sv
module phase_count_det
  import pcd_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned RATE_W = 16,
  parameter int unsigned ERR_W  = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_ce_i,
  input  logic              fb_ce_i,
  input  logic [DIV_W-1:0]  ref_div_i,
  input  logic [DIV_W-1:0]  fb_div_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [ERR_W-1:0]  err_o,
  output logic              strobe_o,
  output logic              ovf_o
);
  logic [NUM_PATHS-1:0] ce_vec;
  logic [NUM_PATHS-1:0] tick_vec;
  logic [DIV_W-1:0]     div_arr [NUM_PATHS];
  logic                 strobe;

  assign ce_vec[PATH_REF]  = ref_ce_i;
  assign ce_vec[PATH_FB]   = fb_ce_i;
  assign div_arr[PATH_REF] = ref_div_i;
  assign div_arr[PATH_FB]  = fb_div_i;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    pcd_edge_div #(.DIV_W(DIV_W)) i_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ce_i   (ce_vec[p]),
      .div_i  (div_arr[p]),
      .tick_o (tick_vec[p])
    );
  end

  pcd_rate_gen #(.RATE_W(RATE_W)) i_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rate_i   (rate_i),
    .strobe_o (strobe)
  );

  pcd_diff_acc #(.ERR_W(ERR_W)) i_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .up_i     (tick_vec[PATH_REF]),
    .dn_i     (tick_vec[PATH_FB]),
    .strobe_i (strobe),
    .err_o    (err_o),
    .ovf_o    (ovf_o)
  );

  assign strobe_o = strobe;

  a_r1_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |-> (err_o == '0) && !ovf_o);
  a_r7_err_only_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |=> $stable(err_o));
endmodule

// File: tb/test_phase_count_det.sv
module test_phase_count_det;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W      = 8;
  localparam int SAT_MAX    = (1 << (ERR_W - 1)) - 1;
  localparam int SAT_MIN    = -(1 << (ERR_W - 1));
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ref_ce = 1'b0;
  logic             fb_ce = 1'b0;
  logic [15:0]      ref_div = '0;
  logic [15:0]      fb_div = '0;
  logic [15:0]      rate = 16'd10;
  logic [ERR_W-1:0] err;
  logic             strobe;
  logic             ovf;

  int checks = 0;
  int errors = 0;
  bit rnd_ce = 1'b0;
  bit done = 1'b0;
  string tag = "R5";

  // behavioural model state
  int m_rdc = 0, m_fdc = 0, m_acc = 0, m_rate = 0, m_err = 0;
  bit m_ovf = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  phase_count_det #(.ERR_W(ERR_W)) i_phase_count_det (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ref_ce_i  (ref_ce),
    .fb_ce_i   (fb_ce),
    .ref_div_i (ref_div),
    .fb_div_i  (fb_div),
    .rate_i    (rate),
    .err_o     (err),
    .strobe_o  (strobe),
    .ovf_o     (ovf)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdc = 0; m_fdc = 0; m_acc = 0; m_rate = 0; m_err = 0; m_ovf = 0;
    end else begin
      bit rt, ft, stb;
      int sum;
      rt = ref_ce && (m_rdc >= int'(ref_div) + 1);
      ft = fb_ce && (m_fdc >= int'(fb_div) + 1);
      if (ref_ce) m_rdc = rt ? 0 : m_rdc + 1;
      if (fb_ce)  m_fdc = ft ? 0 : m_fdc + 1;
      sum = m_acc + int'(rt) - int'(ft);
      if (sum > SAT_MAX) begin sum = SAT_MAX; m_ovf = 1; end
      if (sum < SAT_MIN) begin sum = SAT_MIN; m_ovf = 1; end
      stb = m_rate >= int'(rate);
      if (stb) begin m_err = sum; m_acc = 0; m_rate = 0; end
      else begin m_acc = sum; m_rate = m_rate + 1; end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    check(tag, int'($signed(err)), m_err, "err_o");
    check("R6", int'(strobe), int'(m_rate >= int'(rate)), "strobe_o");
    check((tag == "R9") ? "R9" : "R8", int'(ovf), int'(m_ovf), "ovf_o");
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
      if (rnd_ce) begin
        ref_ce = 1'($urandom);
        fb_ce  = 1'($urandom);
      end
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'($signed(err)), 0, "err_o in reset");
    check("R1", int'(ovf), 0, "ovf_o in reset");
    rst_n = 1'b1;

    // R2: reference alone, divide by 5, 20-cycle window
    tag = "R2"; ref_div = 16'd3; rate = 16'd19; ref_ce = 1'b1;
    run(80);
    // R3: feedback alone, divide by 2
    tag = "R3"; ref_ce = 1'b0; fb_div = 16'd0; fb_ce = 1'b1;
    run(80);
    // R4: sparse enables on both paths
    tag = "R4"; ref_div = 16'd2; fb_div = 16'd4; rnd_ce = 1'b1;
    run(300);
    // R5: both running, mismatched ratios
    tag = "R5"; ref_div = 16'd1; fb_div = 16'd2; rate = 16'd63; rnd_ce = 1'b0;
    ref_ce = 1'b1; fb_ce = 1'b1;
    run(400);
    // R6: strobe every cycle, then rate changes mid-count
    tag = "R6"; rate = 16'd0;
    run(20);
    rate = 16'd40;
    run(25);
    rate = 16'd7;
    run(60);
    // R7: random traffic with a mid-length window
    tag = "R7"; rate = 16'd33; rnd_ce = 1'b1; ref_div = 16'd0; fb_div = 16'd1;
    run(400);
    // R8: drive positive then negative saturation
    tag = "R8"; rnd_ce = 1'b0; ref_ce = 1'b1; fb_ce = 1'b0; ref_div = 16'd0; rate = 16'd400;
    run(820);
    ref_ce = 1'b0; fb_ce = 1'b1; fb_div = 16'd0;
    run(820);
    // R9: balanced traffic, flag must stay set
    tag = "R9"; ref_ce = 1'b1; fb_ce = 1'b1; ref_div = 16'd1; fb_div = 16'd1; rate = 16'd15;
    run(200);
    // R1: reset clears flag and error again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", int'($signed(err)), 0, "err_o after reset pulse");
    check("R1", int'(ovf), 0, "ovf_o after reset pulse");
    rst_n = 1'b1;
    tag = "R5"; ref_div = 16'd5; fb_div = 16'd3; rate = 16'd99;
    run(400);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual hung expected completion");
      finish_run();
    end
  end
endmodule